// File: doc/BRIEF.md
# Split Instruction/Data Request Dispatcher

This block sits at the front of a private cache whose lines live in two separate arrays, one for instructions and one for data. Each cycle it picks one of two sources: a coherence message arriving from the next cache level, or the head of the processor's request queue. It turns that into a single event for the line controller. Incoming messages are decoded by class. Processor requests are steered to the array they belong to, and the dispatcher decides whether the request may go ahead or whether a line must first be evicted.

The tag arrays sit outside the block. They answer a lookup on the request address through plain inputs: a hit flag for each array, a free-way flag for the addressed set in each array, and the victim line address each array would choose. The line controller reports through a stall input that the requested line has a transaction in flight. A request that cannot proceed is not consumed. It stays at the head of its queue and is presented again later. The result is one registered event: a valid bit, an event code, a line address and an array select.

Top module: `split_dispatch`

## Requirements
- R1: After reset, `ev_valid`, `err_flag`, `msg_take` and `req_take` are all 0 while both sources are idle.
- R2: When `msg_valid` and `req_valid` are both high, the message is serviced (`msg_take`=1) and the request is held (`req_take`=0).
- R3: Message classes decode to these event codes: class 0 (exclusive data) to 5, class 1 (shared data) to 6, class 2 (ack) to 7, class 3 (writeback ack) to 8, class 4 (invalidate) to 9, class 5 (exclusive fetch) to 10, class 7 (shared fetch) to 11, class 8 (instruction fetch) to 12. The event carries the message address.
- R4: Message class 6 (upgrade) is decoded as a forwarded exclusive fetch, event code 10.
- R5: A message with class 9 to 15 is consumed without producing an event, and it sets `err_flag`. `err_flag` stays set until reset.
- R6: Request kinds are 0 load, 1 fetch, 2 store and 3 atomic. A fetch targets the instruction array (`ev_instr`=1). Loads, stores and atomics target the data array (`ev_instr`=0). An atomic issues the store event.
- R7: If the request hits its own array, or misses with a free way in its set, the request is consumed. It emits its own event with the request address: load 1, fetch 2, store 3.
- R8: If the line is present in the opposite array, a replacement event (code 4) for the request address is emitted on that opposite array. The request is not consumed.
- R9: If the request misses its own array and its set has no free way, a replacement event (code 4) is emitted on its own array, using that array's victim address. The request is not consumed.
- R10: While `line_stalled` is high and no message is pending, a request is neither consumed nor turned into an event.
- R11: A lookup must never report the line present in both arrays at once.
- R12: An event appears on the outputs exactly one clock after the cycle in which its source was selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | A coherence message is waiting |
| msg_class | input | 4 | Class of the waiting message |
| msg_addr | input | AW | Line address of the message |
| msg_take | output | 1 | Message consumed this cycle |
| req_valid | input | 1 | A processor request is at the queue head |
| req_kind | input | 2 | 0 load, 1 fetch, 2 store, 3 atomic |
| req_addr | input | AW | Line address of the request |
| req_take | output | 1 | Request consumed this cycle |
| ia_hit | input | 1 | Request line present in the instruction array |
| da_hit | input | 1 | Request line present in the data array |
| ia_room | input | 1 | Instruction-array set has a free way |
| da_room | input | 1 | Data-array set has a free way |
| ia_victim | input | AW | Victim line chosen by the instruction array |
| da_victim | input | AW | Victim line chosen by the data array |
| line_stalled | input | 1 | Request line has a transaction in flight |
| ev_valid | output | 1 | Event valid |
| ev_code | output | 4 | Event code |
| ev_addr | output | AW | Event line address |
| ev_instr | output | 1 | Array select: 1 instruction, 0 data |
| err_flag | output | 1 | Sticky unknown-class error |

## Verification
The bound checker watches several rules on every cycle:
- a pending message always blocks the request;
- an upgrade always becomes a forwarded exclusive fetch;
- an unknown class never produces an event, and the error flag never clears;
- a stalled request produces nothing;
- a replacement never coincides with consuming the request;
- the lookup never reports both arrays.

Some behaviour is only visible in the bench's scenarios, where the scoreboard compares full events against expected ones. This covers the exact code for every message class, the choice of array and address for each request kind, and the choice among own-hit, opposite-array eviction and full-set eviction.

// File: rtl/split_dispatch_pkg.sv
package split_dispatch_pkg;

    // message classes from the next cache level
    typedef enum logic [3:0] {
        MC_DATA_EXCL = 4'd0,
        MC_DATA      = 4'd1,
        MC_ACK       = 4'd2,
        MC_WB_ACK    = 4'd3,
        MC_INV       = 4'd4,
        MC_GETX      = 4'd5,
        MC_UPGRADE   = 4'd6,
        MC_GETS      = 4'd7,
        MC_GETI      = 4'd8
    } msg_class_e;

    // processor request kinds
    typedef enum logic [1:0] {
        RK_LOAD   = 2'd0,
        RK_FETCH  = 2'd1,
        RK_STORE  = 2'd2,
        RK_ATOMIC = 2'd3
    } req_kind_e;

    // events for the line controller
    typedef enum logic [3:0] {
        EV_NONE      = 4'd0,
        EV_LOAD      = 4'd1,
        EV_FETCH     = 4'd2,
        EV_STORE     = 4'd3,
        EV_REPL      = 4'd4,
        EV_DATA_EXCL = 4'd5,
        EV_DATA      = 4'd6,
        EV_ACK       = 4'd7,
        EV_WB_ACK    = 4'd8,
        EV_INV       = 4'd9,
        EV_FWD_GETX  = 4'd10,
        EV_FWD_GETS  = 4'd11,
        EV_FWD_GETI  = 4'd12
    } event_e;

    typedef struct packed {
        logic   legal;
        event_e code;
    } decode_t;

    typedef struct packed {
        logic   valid;
        event_e code;
        logic   instr;
    } ev_head_t;

    function automatic decode_t decode_class(input logic [3:0] cls);
        decode_t d;
        d.legal = 1'b1;
        unique case (cls)
            MC_DATA_EXCL: d.code = EV_DATA_EXCL;
            MC_DATA:      d.code = EV_DATA;
            MC_ACK:       d.code = EV_ACK;
            MC_WB_ACK:    d.code = EV_WB_ACK;
            MC_INV:       d.code = EV_INV;
            MC_GETX,
            MC_UPGRADE:   d.code = EV_FWD_GETX;
            MC_GETS:      d.code = EV_FWD_GETS;
            MC_GETI:      d.code = EV_FWD_GETI;
            default: begin
                d.legal = 1'b0;
                d.code  = EV_NONE;
            end
        endcase
        return d;
    endfunction

    function automatic event_e kind_event(input logic [1:0] kind);
        event_e e;
        unique case (kind)
            RK_LOAD:  e = EV_LOAD;
            RK_FETCH: e = EV_FETCH;
            default:  e = EV_STORE;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/split_dispatch_msg_dec.sv
module split_dispatch_msg_dec
    import split_dispatch_pkg::*;
(
    input  logic [3:0] cls,
    output logic       legal,
    output event_e     code
);
    decode_t dec;

    always_comb begin
        dec   = decode_class(cls);
        legal = dec.legal;
        code  = dec.code;
    end
endmodule

// File: rtl/split_dispatch_router.sv
module split_dispatch_router
    import split_dispatch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [1:0]    kind,
    input  logic [AW-1:0] addr,
    input  logic          ia_hit,
    input  logic          da_hit,
    input  logic          ia_room,
    input  logic          da_room,
    input  logic [AW-1:0] ia_victim,
    input  logic [AW-1:0] da_victim,
    output logic          proceed,
    output event_e        code,
    output logic [AW-1:0] out_addr,
    output logic          instr
);
    logic          is_fetch;
    logic          own_hit;
    logic          other_hit;
    logic          own_room;
    logic [AW-1:0] own_victim;

    always_comb begin
        is_fetch   = (kind == RK_FETCH);
        own_hit    = is_fetch ? ia_hit    : da_hit;
        other_hit  = is_fetch ? da_hit    : ia_hit;
        own_room   = is_fetch ? ia_room   : da_room;
        own_victim = is_fetch ? ia_victim : da_victim;

        if (other_hit) begin
            // evict from the opposite array first
            proceed  = 1'b0;
            code     = EV_REPL;
            out_addr = addr;
            instr    = ~is_fetch;
        end else if (own_hit || own_room) begin
            proceed  = 1'b1;
            code     = kind_event(kind);
            out_addr = addr;
            instr    = is_fetch;
        end else begin
            // set full: evict the array's victim
            proceed  = 1'b0;
            code     = EV_REPL;
            out_addr = own_victim;
            instr    = is_fetch;
        end
    end
endmodule

// File: rtl/split_dispatch_arb.sv
module split_dispatch_arb
    import split_dispatch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          msg_valid,
    input  logic          msg_legal,
    input  event_e        msg_code,
    input  logic [AW-1:0] msg_addr,
    input  logic          req_valid,
    input  logic          stalled,
    input  logic          rt_proceed,
    input  event_e        rt_code,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_instr,
    output logic          msg_take,
    output logic          req_take,
    output ev_head_t      ev_q,
    output logic [AW-1:0] ev_addr_q,
    output logic          err_q
);
    ev_head_t      ev_d;
    logic [AW-1:0] addr_d;
    logic          req_go;

    always_comb begin
        ev_d   = '{valid: 1'b0, code: EV_NONE, instr: 1'b0};
        addr_d = '0;
        req_go = req_valid && !msg_valid && !stalled;
        if (msg_valid) begin
            ev_d.valid = msg_legal;
            ev_d.code  = msg_legal ? msg_code : EV_NONE;
            addr_d     = msg_addr;
        end else if (req_go) begin
            ev_d.valid = 1'b1;
            ev_d.code  = rt_code;
            ev_d.instr = rt_instr;
            addr_d     = rt_addr;
        end
        msg_take = msg_valid;
        req_take = req_go && rt_proceed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q      <= '{valid: 1'b0, code: EV_NONE, instr: 1'b0};
            ev_addr_q <= '0;
            err_q     <= 1'b0;
        end else begin
            ev_q      <= ev_d;
            ev_addr_q <= addr_d;
            if (msg_valid && !msg_legal)
                err_q <= 1'b1;
        end
    end
endmodule

// File: rtl/split_dispatch.sv
module split_dispatch
    import split_dispatch_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          msg_valid,
    input  logic [3:0]    msg_class,
    input  logic [AW-1:0] msg_addr,
    output logic          msg_take,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    output logic          req_take,
    input  logic          ia_hit,
    input  logic          da_hit,
    input  logic          ia_room,
    input  logic          da_room,
    input  logic [AW-1:0] ia_victim,
    input  logic [AW-1:0] da_victim,
    input  logic          line_stalled,
    output logic          ev_valid,
    output logic [3:0]    ev_code,
    output logic [AW-1:0] ev_addr,
    output logic          ev_instr,
    output logic          err_flag
);
    logic          m_legal;
    event_e        m_code;
    logic          r_proceed;
    event_e        r_code;
    logic [AW-1:0] r_addr;
    logic          r_instr;
    ev_head_t      head;

    split_dispatch_msg_dec u_dec (
        .cls   (msg_class),
        .legal (m_legal),
        .code  (m_code)
    );

    split_dispatch_router #(.AW(AW)) u_route (
        .kind      (req_kind),
        .addr      (req_addr),
        .ia_hit    (ia_hit),
        .da_hit    (da_hit),
        .ia_room   (ia_room),
        .da_room   (da_room),
        .ia_victim (ia_victim),
        .da_victim (da_victim),
        .proceed   (r_proceed),
        .code      (r_code),
        .out_addr  (r_addr),
        .instr     (r_instr)
    );

    split_dispatch_arb #(.AW(AW)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (msg_valid),
        .msg_legal  (m_legal),
        .msg_code   (m_code),
        .msg_addr   (msg_addr),
        .req_valid  (req_valid),
        .stalled    (line_stalled),
        .rt_proceed (r_proceed),
        .rt_code    (r_code),
        .rt_addr    (r_addr),
        .rt_instr   (r_instr),
        .msg_take   (msg_take),
        .req_take   (req_take),
        .ev_q       (head),
        .ev_addr_q  (ev_addr),
        .err_q      (err_flag)
    );

    assign ev_valid = head.valid;
    assign ev_code  = head.code;
    assign ev_instr = head.instr;
endmodule

// File: rtl/split_dispatch_chk.sv
module split_dispatch_chk #(
    parameter int AW = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       msg_valid,
    input logic [3:0] msg_class,
    input logic       req_valid,
    input logic       req_take,
    input logic       ia_hit,
    input logic       da_hit,
    input logic       line_stalled,
    input logic       ev_valid,
    input logic [3:0] ev_code,
    input logic       err_flag
);
    p_msg_first_r2: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !req_take);

    p_upgrade_r4: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_class == 4'd6) |=> (ev_valid && ev_code == 4'd10));

    p_bad_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_class > 4'd8) |=> (!ev_valid && err_flag));

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    p_repl_held_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_code == 4'd4) |-> ($past(req_valid) && !$past(req_take)));

    p_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && line_stalled && !msg_valid) |=> !ev_valid);

    p_one_copy_r11: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !(ia_hit && da_hit));

    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
        req_take |=> ev_valid);
endmodule

bind split_dispatch split_dispatch_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .msg_valid    (msg_valid),
    .msg_class    (msg_class),
    .req_valid    (req_valid),
    .req_take     (req_take),
    .ia_hit       (ia_hit),
    .da_hit       (da_hit),
    .line_stalled (line_stalled),
    .ev_valid     (ev_valid),
    .ev_code      (ev_code),
    .err_flag     (err_flag)
);

// File: tb/split_dispatch_test.sv
module split_dispatch_test;
    localparam int AW = 16;
    localparam logic [AW-1:0] IVIC = 16'hA0A0;
    localparam logic [AW-1:0] DVIC = 16'hD0D0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic msg_valid = 0, req_valid = 0;
    logic [3:0] msg_class = 0;
    logic [AW-1:0] msg_addr = 0, req_addr = 0;
    logic [1:0] req_kind = 0;
    logic ia_hit = 0, da_hit = 0, ia_room = 0, da_room = 0, line_stalled = 0;
    logic msg_take, req_take, ev_valid, ev_instr, err_flag;
    logic [3:0] ev_code;
    logic [AW-1:0] ev_addr;

    int checks = 0;
    int errors = 0;
    logic sticky_err = 1'b0;

    typedef struct {
        logic          ev;
        logic [3:0]    code;
        logic [AW-1:0] addr;
        logic          instr;
        logic          err;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    split_dispatch #(.AW(AW)) uut (
        .clk(clk), .rst(rst),
        .msg_valid(msg_valid), .msg_class(msg_class), .msg_addr(msg_addr), .msg_take(msg_take),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_take(req_take),
        .ia_hit(ia_hit), .da_hit(da_hit), .ia_room(ia_room), .da_room(da_room),
        .ia_victim(IVIC), .da_victim(DVIC), .line_stalled(line_stalled),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_addr(ev_addr), .ev_instr(ev_instr),
        .err_flag(err_flag)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // driver: one cycle of stimulus; lookup = {ia_hit, da_hit, ia_room, da_room}
    task automatic cyc(input logic mv, input logic [3:0] mc, input logic [AW-1:0] ma,
                       input logic rv, input logic [1:0] rk, input logic [AW-1:0] ra,
                       input logic [3:0] look, input logic stl, input logic x_rt,
                       input logic x_ev, input logic [3:0] x_code,
                       input logic [AW-1:0] x_addr, input logic x_instr, input string tag);
        exp_t e;
        @(negedge clk);
        msg_valid = mv; msg_class = mc; msg_addr = ma;
        req_valid = rv; req_kind = rk; req_addr = ra;
        {ia_hit, da_hit, ia_room, da_room} = look;
        line_stalled = stl;
        if (mv && mc > 4'd8) sticky_err = 1'b1;
        e.ev = x_ev; e.code = x_code; e.addr = x_addr; e.instr = x_instr;
        e.err = sticky_err; e.tag = tag;
        sb.push_back(e);
        #1;
        check(msg_take == mv, tag, "msg_take", int'(msg_take), int'(mv));
        check(req_take == x_rt, tag, "req_take", int'(req_take), int'(x_rt));
    endtask

    // monitor: compare the registered event one clock after the driving cycle (R12)
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(ev_valid == e.ev, e.tag, "ev_valid", int'(ev_valid), int'(e.ev));
                if (e.ev) begin
                    check(ev_code == e.code, e.tag, "ev_code", int'(ev_code), int'(e.code));
                    check(ev_addr == e.addr, e.tag, "ev_addr", int'(ev_addr), int'(e.addr));
                    check(ev_instr == e.instr, e.tag, "ev_instr", int'(ev_instr), int'(e.instr));
                end
                check(err_flag == e.err, e.tag, "err_flag", int'(err_flag), int'(e.err));
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(ev_valid == 0, "R1", "ev_valid", int'(ev_valid), 0);
        check(err_flag == 0, "R1", "err_flag", int'(err_flag), 0);
        check(msg_take == 0 && req_take == 0, "R1", "takes",
              int'({msg_take, req_take}), 0);

        // R3 each legal message class
        cyc(1, 4'd0, 16'h0100, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd5,  16'h0100, 0, "R3");
        cyc(1, 4'd1, 16'h0101, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd6,  16'h0101, 0, "R3");
        cyc(1, 4'd2, 16'h0102, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd7,  16'h0102, 0, "R3");
        cyc(1, 4'd3, 16'h0103, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd8,  16'h0103, 0, "R3");
        cyc(1, 4'd4, 16'h0104, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd9,  16'h0104, 0, "R3");
        cyc(1, 4'd5, 16'h0105, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd10, 16'h0105, 0, "R3");
        cyc(1, 4'd7, 16'h0107, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd11, 16'h0107, 0, "R3");
        cyc(1, 4'd8, 16'h0108, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd12, 16'h0108, 0, "R3");
        // R4 upgrade becomes forwarded exclusive fetch
        cyc(1, 4'd6, 16'h0106, 0, 0, 0, 4'b0000, 0, 0, 1, 4'd10, 16'h0106, 0, "R4");

        // R2 message wins over a ready load
        cyc(1, 4'd1, 16'h0200, 1, 2'd0, 16'h0300, 4'b0101, 0, 0, 1, 4'd6, 16'h0200, 0, "R2");

        // R6/R7 requests that proceed
        cyc(0, 0, 0, 1, 2'd0, 16'h0301, 4'b0101, 0, 1, 1, 4'd1, 16'h0301, 0, "R7");
        cyc(0, 0, 0, 1, 2'd1, 16'h0302, 4'b0010, 0, 1, 1, 4'd2, 16'h0302, 1, "R6");
        cyc(0, 0, 0, 1, 2'd2, 16'h0303, 4'b0001, 0, 1, 1, 4'd3, 16'h0303, 0, "R7");
        cyc(0, 0, 0, 1, 2'd3, 16'h0304, 4'b0100, 0, 1, 1, 4'd3, 16'h0304, 0, "R6");

        // R8 line in the opposite array
        cyc(0, 0, 0, 1, 2'd2, 16'h0305, 4'b1011, 0, 0, 1, 4'd4, 16'h0305, 1, "R8");
        cyc(0, 0, 0, 1, 2'd1, 16'h0306, 4'b0111, 0, 0, 1, 4'd4, 16'h0306, 0, "R8");

        // R9 full set: victim of own array
        cyc(0, 0, 0, 1, 2'd0, 16'h0307, 4'b0010, 0, 0, 1, 4'd4, DVIC, 0, "R9");
        cyc(0, 0, 0, 1, 2'd1, 16'h0308, 4'b0001, 0, 0, 1, 4'd4, IVIC, 1, "R9");

        // R10 stalled line
        cyc(0, 0, 0, 1, 2'd0, 16'h0309, 4'b0101, 1, 0, 0, 4'd0, 0, 0, "R10");
        cyc(0, 0, 0, 1, 2'd1, 16'h030A, 4'b0000, 1, 0, 0, 4'd0, 0, 0, "R10");

        // R5 unknown class: dropped, flag set and held
        cyc(1, 4'd12, 16'h0400, 0, 0, 0, 4'b0000, 0, 0, 0, 4'd0, 0, 0, "R5");
        cyc(1, 4'd9,  16'h0401, 1, 2'd0, 16'h0310, 4'b0101, 0, 0, 0, 4'd0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 0, 4'b0000, 0, 0, 0, 4'd0, 0, 0, "R5");
        // R11 is asserted in the checker; lookups above never report both arrays
        cyc(0, 0, 0, 1, 2'd0, 16'h0311, 4'b0101, 0, 1, 1, 4'd1, 16'h0311, 0, "R11");
        cyc(0, 0, 0, 0, 0, 0, 4'b0000, 0, 0, 0, 4'd0, 0, 0, "R12");

        repeat (3) @(posedge clk);
        #3;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule